// File: doc/BRIEF.md
# Security-Banked System Control Register

This block holds the core's main system control word. One part of the word is kept twice: a secure copy and a non-secure copy. Each access uses the copy that belongs to the current security state. A second part is kept only once. Only the secure world may change it, although both worlds can read it. The configuration outputs (MMU enable, strict alignment, data cache enable, high vectors, unaligned-access enable and exception endianness) are taken from the copy that matches the current security state. They drive the rest of the core.

A coprocessor register access arrives as a one-cycle strobe. It carries a read/write flag, four selector fields and the current mode: privileged or user, secure or non-secure. The block answers in the same cycle. It returns read data, or it raises an undefined-instruction flag when the access is not allowed. A lock input blocks secure writes. A strap input sets the reset value of the high-vectors bit.

Top module: `sec_ctrl_reg`

## Requirements
- R1: A selected read or write in user mode, secure or non-secure, raises `undef_o`, returns zero read data and changes no stored bit.
- R2: A selected privileged secure write while `sec_wr_lock_i` is 1 raises `undef_o` and changes nothing. Non-secure privileged writes and all privileged reads are not affected by the lock.
- R3: The secure-only bits are 22 (unaligned-access enable) and 25 (exception big-endian). Only a privileged secure write changes them; a non-secure privileged write leaves them as they were. Reads from either world return the single stored value.
- R4: The banked bits are 0, 1, 2 and 13. A privileged access reads and writes the copy of its own world and never touches the other copy.
- R5: The register is selected only when op1=0, crn=1, crm=0 and op2=0. Any other field combination gives no `undef_o`, zero read data and no change of state.
- R6: The bit map is: bit 0 MMU enable, bit 1 strict alignment, bit 2 data cache enable, bit 13 high vectors. All other bits read as zero and ignore writes.
- R7: While `rst_ni` is low, both copies of bits 0, 1 and 2 clear to 0. Bit 13 of both copies takes the value of `vec_strap_i`. The secure-only bits clear to 0.
- R8: `unaligned_en_o` equals bit 22 AND NOT bit 1 of the current world's copy. A set strict-alignment bit overrides the unaligned enable.
- R9: `undef_o` and `req_rdata_o` respond in the cycle the strobe is high. Read data is non-zero only for an allowed read. A write shows in reads and outputs from the next clock edge on.
- R10: The configuration outputs follow the copy selected by `mode_secure_i`, and they switch as soon as that input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_op1_i | input | 3 | First opcode field |
| req_crn_i | input | 4 | Primary register selector |
| req_crm_i | input | 4 | Secondary register selector |
| req_op2_i | input | 3 | Second opcode field |
| req_wdata_i | input | 32 | Write data |
| mode_priv_i | input | 1 | 1 = privileged, 0 = user |
| mode_secure_i | input | 1 | 1 = secure world, 0 = non-secure |
| sec_wr_lock_i | input | 1 | Blocks secure writes when high |
| vec_strap_i | input | 1 | Reset value of the high-vectors bit |
| req_rdata_o | output | 32 | Read data, zero unless an allowed read |
| undef_o | output | 1 | Undefined-instruction flag |
| mmu_en_o | output | 1 | Current world MMU enable |
| align_strict_o | output | 1 | Current world strict alignment |
| dcache_en_o | output | 1 | Current world data cache enable |
| high_vec_o | output | 1 | Current world high vectors |
| unaligned_en_o | output | 1 | Effective unaligned-access enable |
| exc_big_endian_o | output | 1 | Exception endianness |

## Verification
Each write-data pattern is swept through all sixteen combinations of privilege, world, lock and direction. The patterns are all ones, all zeros, one with only the secure-only bits set, and words that set or clear the alignment bit together with the unaligned enable. The all-ones and all-zeros words show whether a bit leaked into the other world or into an unimplemented position. The mixed words show whether secure-only bits were wrongly accepted from the non-secure world, and whether the alignment override is applied. After every access both worlds are read back and their outputs compared. So a change that lands in the wrong copy is caught, and so is a blocked access that still changes a bit. A sweep over every non-matching selector field shows whether decoding is too loose. Two resets with opposite strap values show whether the high-vectors bit takes its value from the strap.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned BIT_MMU    = 0;
  localparam int unsigned BIT_ALIGN  = 1;
  localparam int unsigned BIT_DCACHE = 2;
  localparam int unsigned BIT_HIVEC  = 13;
  localparam int unsigned BIT_UNAL   = 22;
  localparam int unsigned BIT_EXC_BE = 25;

  localparam logic [REG_W-1:0] BANK_MASK =
    (REG_W'(1) << BIT_MMU) | (REG_W'(1) << BIT_ALIGN) |
    (REG_W'(1) << BIT_DCACHE) | (REG_W'(1) << BIT_HIVEC);
  localparam logic [REG_W-1:0] SMO_MASK =
    (REG_W'(1) << BIT_UNAL) | (REG_W'(1) << BIT_EXC_BE);
  localparam logic [REG_W-1:0] IMPL_MASK = BANK_MASK | SMO_MASK;

  localparam logic [2:0] SEL_OP1 = 3'd0;
  localparam logic [3:0] SEL_CRN = 4'd1;
  localparam logic [3:0] SEL_CRM = 4'd0;
  localparam logic [2:0] SEL_OP2 = 3'd0;

  localparam int unsigned N_WORLD = 2;
  localparam int unsigned W_NS    = 0;
  localparam int unsigned W_SEC   = 1;

  typedef struct packed {
    logic hit;
    logic undef;
    logic rd_ok;
    logic wr_sec;
    logic wr_ns;
  } scr_dec_t;
endpackage

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       write_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic       priv_i,
  input  logic       secure_i,
  input  logic       lock_i,
  output scr_dec_t   dec_o
);
  logic sel;
  logic blocked;

  assign sel     = valid_i && (op1_i == SEL_OP1) && (crn_i == SEL_CRN) &&
                   (crm_i == SEL_CRM) && (op2_i == SEL_OP2);
  // user mode never reaches the register; secure writes obey the lock
  assign blocked = !priv_i || (write_i && secure_i && lock_i);

  always_comb begin
    dec_o        = '0;
    dec_o.hit    = sel;
    dec_o.undef  = sel && blocked;
    dec_o.rd_ok  = sel && !blocked && !write_i;
    dec_o.wr_sec = sel && !blocked && write_i && secure_i;
    dec_o.wr_ns  = sel && !blocked && write_i && !secure_i;
  end

  p_undef_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o.undef |-> valid_i);
  p_one_action_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({dec_o.undef, dec_o.rd_ok, dec_o.wr_sec, dec_o.wr_ns}) <= 1);
  p_user_undef_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o.hit && !priv_i) |-> dec_o.undef);
endmodule

// File: rtl/scr_field_reg.sv
module scr_field_reg #(
  parameter int unsigned         W    = 32,
  parameter logic [W-1:0]        MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rst_val_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // reset value is sampled for as long as reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= rst_val_i & MASK;
    else if (we_i) q <= wdata_i & MASK;
  end

  assign q_o = q;
endmodule

// File: rtl/scr_cfg_map.sv
module scr_cfg_map
  import scr_pkg::*;
(
  input  logic [REG_W-1:0] bank_i,
  input  logic [REG_W-1:0] smo_i,
  output logic             mmu_en_o,
  output logic             align_strict_o,
  output logic             dcache_en_o,
  output logic             high_vec_o,
  output logic             unaligned_en_o,
  output logic             exc_big_endian_o
);
  assign mmu_en_o         = bank_i[BIT_MMU];
  assign align_strict_o   = bank_i[BIT_ALIGN];
  assign dcache_en_o      = bank_i[BIT_DCACHE];
  assign high_vec_o       = bank_i[BIT_HIVEC];
  // strict alignment wins over the unaligned enable
  assign unaligned_en_o   = smo_i[BIT_UNAL] && !bank_i[BIT_ALIGN];
  assign exc_big_endian_o = smo_i[BIT_EXC_BE];
endmodule

// File: rtl/sec_ctrl_reg.sv
module sec_ctrl_reg
  import scr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [2:0]       req_op1_i,
  input  logic [3:0]       req_crn_i,
  input  logic [3:0]       req_crm_i,
  input  logic [2:0]       req_op2_i,
  input  logic [REG_W-1:0] req_wdata_i,
  input  logic             mode_priv_i,
  input  logic             mode_secure_i,
  input  logic             sec_wr_lock_i,
  input  logic             vec_strap_i,
  output logic [REG_W-1:0] req_rdata_o,
  output logic             undef_o,
  output logic             mmu_en_o,
  output logic             align_strict_o,
  output logic             dcache_en_o,
  output logic             high_vec_o,
  output logic             unaligned_en_o,
  output logic             exc_big_endian_o
);
  scr_dec_t                        dec;
  logic [N_WORLD-1:0]              bank_we;
  logic [N_WORLD-1:0][REG_W-1:0]   bank_q;
  logic [REG_W-1:0]                bank_rst;
  logic [REG_W-1:0]                smo_q;
  logic [REG_W-1:0]                cur_bank;

  scr_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req_valid_i),
    .write_i  (req_write_i),
    .op1_i    (req_op1_i),
    .crn_i    (req_crn_i),
    .crm_i    (req_crm_i),
    .op2_i    (req_op2_i),
    .priv_i   (mode_priv_i),
    .secure_i (mode_secure_i),
    .lock_i   (sec_wr_lock_i),
    .dec_o    (dec)
  );

  assign bank_rst = REG_W'(vec_strap_i) << BIT_HIVEC;

  generate
    for (genvar w = 0; w < N_WORLD; w++) begin : g_bank
      assign bank_we[w] = (w == W_SEC) ? dec.wr_sec : dec.wr_ns;
      scr_field_reg #(.W(REG_W), .MASK(BANK_MASK)) u_copy (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rst_val_i (bank_rst),
        .we_i      (bank_we[w]),
        .wdata_i   (req_wdata_i),
        .q_o       (bank_q[w])
      );
    end
  endgenerate

  scr_field_reg #(.W(REG_W), .MASK(SMO_MASK)) u_smo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_val_i ('0),
    .we_i      (dec.wr_sec),
    .wdata_i   (req_wdata_i),
    .q_o       (smo_q)
  );

  assign cur_bank    = mode_secure_i ? bank_q[W_SEC] : bank_q[W_NS];
  assign req_rdata_o = dec.rd_ok ? (cur_bank | smo_q) : '0;
  assign undef_o     = dec.undef;

  scr_cfg_map u_map (
    .bank_i           (cur_bank),
    .smo_i            (smo_q),
    .mmu_en_o         (mmu_en_o),
    .align_strict_o   (align_strict_o),
    .dcache_en_o      (dcache_en_o),
    .high_vec_o       (high_vec_o),
    .unaligned_en_o   (unaligned_en_o),
    .exc_big_endian_o (exc_big_endian_o)
  );

  p_user_frozen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.hit && !mode_priv_i) |=> ($stable(bank_q) && $stable(smo_q)));
  p_lock_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.hit && req_write_i && mode_secure_i && sec_wr_lock_i)
      |=> ($stable(bank_q) && $stable(smo_q)));
  p_smo_ns_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.hit && req_write_i && !mode_secure_i) |=> $stable(smo_q));
  p_ns_isolated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.hit && mode_secure_i) |=> $stable(bank_q[W_NS]));
  p_sec_isolated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.hit && !mode_secure_i) |=> $stable(bank_q[W_SEC]));
  p_miss_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !dec.hit) |-> (!undef_o && req_rdata_o == '0));
  p_unimpl_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_rdata_o & ~IMPL_MASK) == '0);
  p_align_override_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_strict_o |-> !unaligned_en_o);
  p_idle_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(bank_q) && $stable(smo_q)));
endmodule

// File: tb/sec_ctrl_reg_bench.sv
module sec_ctrl_reg_bench;
  localparam logic [31:0] BM = 32'h0000_2007;
  localparam logic [31:0] SM = 32'h0240_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, wr;
  logic [2:0]  op1, op2;
  logic [3:0]  crn, crm;
  logic [31:0] wdata;
  logic        priv, sec, lock, strap;
  logic [31:0] rdata;
  logic        undef, mmu, aln, dc, hv, unal, ebe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_sec, m_ns, m_smo;

  always #4 clk = ~clk;

  sec_ctrl_reg u_sec_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr),
    .req_op1_i(op1), .req_crn_i(crn), .req_crm_i(crm), .req_op2_i(op2),
    .req_wdata_i(wdata), .mode_priv_i(priv), .mode_secure_i(sec),
    .sec_wr_lock_i(lock), .vec_strap_i(strap), .req_rdata_o(rdata),
    .undef_o(undef), .mmu_en_o(mmu), .align_strict_o(aln), .dcache_en_o(dc),
    .high_vec_o(hv), .unaligned_en_o(unal), .exc_big_endian_o(ebe)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 1'b0; strap = s;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_sec = s ? 32'h2000 : 32'h0;
    m_ns  = m_sec;
    m_smo = 32'h0;
  endtask

  // one access; returns same-cycle undef and read data
  task automatic acc(input bit w, input logic [2:0] o1, input logic [3:0] cn,
                     input logic [3:0] cm, input logic [2:0] o2, input logic [31:0] d,
                     input bit p, input bit s, input bit l,
                     output logic u, output logic [31:0] rd);
    @(negedge clk);
    valid = 1'b1; wr = w; op1 = o1; crn = cn; crm = cm; op2 = o2;
    wdata = d; priv = p; sec = s; lock = l;
    #1;
    u = undef; rd = rdata;
    @(posedge clk);
    #1 valid = 1'b0;
  endtask

  task automatic chk_outputs(input string tag, input bit s);
    logic [31:0] b;
    @(negedge clk);
    sec = s;
    #1;
    b = s ? m_sec : m_ns;
    chk({tag, " R10 cfg"}, {26'd0, mmu, aln, dc, hv, unal, ebe},
        {26'd0, b[0], b[1], b[2], b[13], m_smo[22] & ~b[1], m_smo[25]});
  endtask

  task automatic verify(input string tag);
    logic u; logic [31:0] rd;
    for (int s = 0; s < 2; s++) begin
      acc(1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, 1'b1, s[0], 1'b0, u, rd);
      chk({tag, " R9 read undef"}, {31'd0, u}, 32'd0);
      chk({tag, " R4 banked"}, rd & BM, s[0] ? m_sec : m_ns);
      chk({tag, " R3 secure-only"}, rd & SM, m_smo);
      chk({tag, " R6 unimpl"}, rd & ~(BM | SM), 32'h0);
      chk_outputs(tag, s[0]);
    end
  endtask

  initial begin
    logic u; logic [31:0] rd;
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0; pats[2] = 32'h0240_0000;
    pats[3] = 32'h0040_0000; pats[4] = 32'h0040_2003; pats[5] = 32'hA5BD_5A5C;
    rst_n = 1'b0; valid = 0; wr = 0; op1 = 0; crn = 0; crm = 0; op2 = 0;
    wdata = 0; priv = 0; sec = 0; lock = 0; strap = 1'b1;

    do_reset(1'b1);
    verify("R7 reset strap=1");

    for (int pi = 0; pi < 6; pi++) begin
      for (int m = 0; m < 16; m++) begin
        bit w, p, s, l, exp_u;
        logic [31:0] exp_rd;
        string tag;
        w = m[0]; p = m[1]; s = m[2]; l = m[3];
        exp_u  = !p || (w && s && l);
        exp_rd = (!w && !exp_u) ? ((s ? m_sec : m_ns) | m_smo) : 32'h0;
        tag = !p ? "R1" : (w && s && l) ? "R2" : "R9";
        acc(w, 3'd0, 4'd1, 4'd0, 3'd0, pats[pi], p, s, l, u, rd);
        chk({tag, " undef"}, {31'd0, u}, {31'd0, exp_u});
        chk({tag, " same-cycle rdata"}, rd, exp_rd);
        if (w && !exp_u) begin
          if (s) begin m_sec = pats[pi] & BM; m_smo = pats[pi] & SM; end
          else m_ns = pats[pi] & BM;
        end
        verify(tag);
      end
    end

    // alignment override seen at the outputs
    acc(1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0040_0002, 1'b1, 1'b1, 1'b0, u, rd);
    m_sec = 32'h2; m_smo = 32'h0040_0000;
    acc(1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, 1'b1, 1'b0, 1'b0, u, rd);
    m_ns = 32'h0;
    chk_outputs("R8", 1'b1);
    chk("R8 secure override", {31'd0, unal}, 32'd0);
    chk_outputs("R8", 1'b0);
    chk("R8 ns enabled", {31'd0, unal}, 32'd1);

    // selector decode sweep
    for (int f = 0; f < 4; f++) begin
      for (int v = 1; v < 16; v++) begin
        logic [2:0] o1; logic [3:0] cn, cm; logic [2:0] o2;
        o1 = 3'd0; cn = 4'd1; cm = 4'd0; o2 = 3'd0;
        if (f == 0 && v < 8) o1 = v[2:0];
        else if (f == 1) cn = (v == 1) ? 4'd0 : v[3:0];
        else if (f == 2) cm = v[3:0];
        else if (f == 3 && v < 8) o2 = v[2:0];
        else continue;
        acc(1'b1, o1, cn, cm, o2, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, u, rd);
        chk("R5 miss write undef", {31'd0, u}, 32'd0);
        acc(1'b0, o1, cn, cm, o2, 32'h0, 1'b0, 1'b0, 1'b0, u, rd);
        chk("R5 miss user undef", {31'd0, u}, 32'd0);
        acc(1'b0, o1, cn, cm, o2, 32'h0, 1'b1, 1'b1, 1'b0, u, rd);
        chk("R5 miss rdata", rd, 32'h0);
      end
    end
    verify("R5 state");

    // non-secure write goes through while the lock is high
    acc(1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, u, rd);
    chk("R2 ns write under lock undef", {31'd0, u}, 32'd0);
    m_ns = BM;
    verify("R2 ns under lock");

    do_reset(1'b0);
    verify("R7 reset strap=0");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule